// File: doc/BRIEF.md
# Control-Flow Address Generator

This block forms every address a 16-bit load/store core needs outside its ALU. A single adder takes a base (the incremented PC or a register value) and an offset (one of three sign-extended instruction fields, or zero). Its sum feeds two destinations: the memory address request for loads and stores, and the next PC for branches and calls. The command input decides which destination, if any, takes the sum in a given step.

Calls also produce a link write: the incremented PC goes to register 7 while the PC is redirected. Trap calls do not use the adder. The low byte of the instruction, zero-extended, is issued as a read of a vector table. The word that comes back is loaded into the PC one cycle later. While the trap finishes, any new command is ignored. All outputs are registered and appear one clock after the inputs that cause them.

Top module: `cf_addr_unit`

## Requirements
- R1: After a synchronous reset, pc_load, link_we, mem_req and busy are 0, and sum_q, pc_next and mem_addr are 0.
- R2: The adder base is pc_inc when base_sel=0 and base_val when base_sel=1. The sum wraps modulo 2^16 and appears on sum_q one cycle later.
- R3: off_sel selects the offset: 0 = sign-extended instr[5:0], 1 = sign-extended instr[8:0], 2 = sign-extended instr[10:0], 3 = zero.
- R4: cmd=1 (memory) gives mem_req=1 and mem_addr equal to the sum one cycle later, with pc_load=0 and link_we=0.
- R5: cmd=2 (branch) gives pc_load equal to br_take and pc_next equal to the sum, with mem_req=0.
- R6: cmd=3 (call) gives pc_load=1, pc_next equal to the sum, link_we=1, link_dst=7 and link_data equal to pc_inc.
- R7: cmd=4 (trap), first cycle: mem_req=1, mem_addr = {8'h00, instr[7:0]}, link_we=1, link_dst=7, link_data=pc_inc, pc_load=0, busy=1.
- R8: Trap, second cycle: the tbl_data presented while busy=1 is loaded, giving pc_load=1 and pc_next=tbl_data, with busy, mem_req and link_we back at 0.
- R9: A command presented while busy=1 is ignored. It raises no mem_req and no link_we, and sum_q keeps its value.
- R10: mem_req and pc_load are never 1 in the same cycle.
- R11: For commands other than call and trap, link_dst equals instr[11:9] and link_we stays 0.
- R12: cmd=0 (idle), and the unused codes 5 to 7, raise no mem_req, pc_load or link_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command: 0 idle, 1 memory, 2 branch, 3 call, 4 trap |
| base_sel | input | 1 | Adder base: 0 PC, 1 register |
| off_sel | input | 2 | Adder offset select (see R3) |
| br_take | input | 1 | Branch condition result |
| instr | input | 16 | Current instruction word |
| pc_inc | input | 16 | Incremented PC of the instruction |
| base_val | input | 16 | Base register value |
| tbl_data | input | 16 | Vector table read data |
| sum_q | output | 16 | Registered adder result |
| pc_next | output | 16 | New PC value |
| pc_load | output | 1 | Load strobe for the PC |
| link_we | output | 1 | Register file write strobe for the link |
| link_dst | output | 3 | Destination register number |
| link_data | output | 16 | Link value (return address) |
| mem_req | output | 1 | Memory address request strobe |
| mem_addr | output | 16 | Memory address |
| busy | output | 1 | Trap completion cycle in progress |

## Verification
Two functions can meet in one cycle: the second half of a trap, which loads the PC from table data, and a fresh memory command that would raise a request from the shared adder. The bench provokes this by driving a memory command with valid selects during the busy cycle. It judges the result by requiring the PC load from tbl_data, no mem_req, no link write and an unchanged sum_q. A checker property also holds at every cycle that the memory and PC destinations never load together.

// File: rtl/cfa_pkg.sv
package cfa_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE   = 3'd0,
    CMD_MEM    = 3'd1,
    CMD_BRANCH = 3'd2,
    CMD_CALL   = 3'd3,
    CMD_TRAP   = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    OFS_F6   = 2'd0,
    OFS_F9   = 2'd1,
    OFS_F11  = 2'd2,
    OFS_ZERO = 2'd3
  } ofs_e;

  localparam int NUM_FIELDS = 3;
endpackage

// File: rtl/cfa_offset_mux.sv
module cfa_offset_mux #(
  parameter int W   = 16,
  parameter int FW0 = 6,
  parameter int FW1 = 9,
  parameter int FW2 = 11
) (
  input  logic [FW2-1:0] field,
  input  logic [1:0]     sel,
  output logic [W-1:0]   ofs
);
  import cfa_pkg::*;
  localparam int FW [NUM_FIELDS] = '{FW0, FW1, FW2};

  logic [W-1:0] cand [NUM_FIELDS+1];

  // one sign extender per offset field width
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_sext
    assign cand[g] = {{(W-FW[g]){field[FW[g]-1]}}, field[FW[g]-1:0]};
  end
  assign cand[NUM_FIELDS] = '0;

  assign ofs = cand[sel];
endmodule

// File: rtl/cfa_adder.sv
module cfa_adder #(
  parameter int W = 16
) (
  input  logic         base_sel,
  input  logic [W-1:0] pc_val,
  input  logic [W-1:0] reg_val,
  input  logic [W-1:0] ofs,
  output logic [W-1:0] sum
);
  logic [W-1:0] base;
  assign base = base_sel ? reg_val : pc_val;
  assign sum  = base + ofs;
endmodule

// File: rtl/cfa_seq.sv
module cfa_seq #(
  parameter int W      = 16,
  parameter int RW     = 3,
  parameter int VEC_W  = 8,
  parameter int LINK_R = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cmd,
  input  logic             br_take,
  input  logic [RW-1:0]    dst_field,
  input  logic [VEC_W-1:0] vec,
  input  logic [W-1:0]     sum,
  input  logic [W-1:0]     pc_inc,
  input  logic [W-1:0]     tbl_data,
  output logic [W-1:0]     sum_q,
  output logic [W-1:0]     pc_next,
  output logic             pc_load,
  output logic             link_we,
  output logic [RW-1:0]    link_dst,
  output logic [W-1:0]     link_data,
  output logic             mem_req,
  output logic [W-1:0]     mem_addr,
  output logic             busy
);
  import cfa_pkg::*;

  cmd_e c;
  logic links;
  assign c     = cmd_e'(cmd);
  assign links = (c == CMD_CALL) || (c == CMD_TRAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q     <= '0;
      pc_next   <= '0;
      pc_load   <= 1'b0;
      link_we   <= 1'b0;
      link_dst  <= '0;
      link_data <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      busy      <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      pc_load <= 1'b0;
      link_we <= 1'b0;
      if (busy) begin
        // trap completion owns this cycle
        busy    <= 1'b0;
        pc_load <= 1'b1;
        pc_next <= tbl_data;
      end else begin
        sum_q    <= sum;
        link_dst <= links ? RW'(LINK_R) : dst_field;
        case (c)
          CMD_MEM: begin
            mem_req  <= 1'b1;
            mem_addr <= sum;
          end
          CMD_BRANCH: begin
            pc_load <= br_take;
            pc_next <= sum;
          end
          CMD_CALL: begin
            pc_load   <= 1'b1;
            pc_next   <= sum;
            link_we   <= 1'b1;
            link_data <= pc_inc;
          end
          CMD_TRAP: begin
            mem_req   <= 1'b1;
            mem_addr  <= {{(W-VEC_W){1'b0}}, vec};
            link_we   <= 1'b1;
            link_data <= pc_inc;
            busy      <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cf_addr_unit.sv
module cf_addr_unit #(
  parameter int W      = 16,
  parameter int RW     = 3,
  parameter int VEC_W  = 8,
  parameter int LINK_R = 7,
  parameter int FW0    = 6,
  parameter int FW1    = 9,
  parameter int FW2    = 11,
  parameter int DST_LO = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    cmd,
  input  logic          base_sel,
  input  logic [1:0]    off_sel,
  input  logic          br_take,
  input  logic [W-1:0]  instr,
  input  logic [W-1:0]  pc_inc,
  input  logic [W-1:0]  base_val,
  input  logic [W-1:0]  tbl_data,
  output logic [W-1:0]  sum_q,
  output logic [W-1:0]  pc_next,
  output logic          pc_load,
  output logic          link_we,
  output logic [RW-1:0] link_dst,
  output logic [W-1:0]  link_data,
  output logic          mem_req,
  output logic [W-1:0]  mem_addr,
  output logic          busy
);
  localparam int DST_HI = DST_LO + RW - 1;

  logic [W-1:0] ofs;
  logic [W-1:0] sum;
  logic         unused_opcode;
  assign unused_opcode = ^instr[W-1:DST_HI+1];

  cfa_offset_mux #(.W(W), .FW0(FW0), .FW1(FW1), .FW2(FW2)) u_ofs (
    .field (instr[FW2-1:0]),
    .sel   (off_sel),
    .ofs   (ofs)
  );

  cfa_adder #(.W(W)) u_add (
    .base_sel (base_sel),
    .pc_val   (pc_inc),
    .reg_val  (base_val),
    .ofs      (ofs),
    .sum      (sum)
  );

  cfa_seq #(.W(W), .RW(RW), .VEC_W(VEC_W), .LINK_R(LINK_R)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .br_take   (br_take),
    .dst_field (instr[DST_HI:DST_LO]),
    .vec       (instr[VEC_W-1:0]),
    .sum       (sum),
    .pc_inc    (pc_inc),
    .tbl_data  (tbl_data),
    .sum_q     (sum_q),
    .pc_next   (pc_next),
    .pc_load   (pc_load),
    .link_we   (link_we),
    .link_dst  (link_dst),
    .link_data (link_data),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .busy      (busy)
  );
endmodule

// File: rtl/cfa_checker.sv
module cfa_checker #(
  parameter int W  = 16,
  parameter int RW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    cmd,
  input logic [W-1:0]  instr,
  input logic [W-1:0]  pc_inc,
  input logic [W-1:0]  tbl_data,
  input logic [W-1:0]  sum_q,
  input logic [W-1:0]  pc_next,
  input logic          pc_load,
  input logic          link_we,
  input logic [RW-1:0] link_dst,
  input logic [W-1:0]  link_data,
  input logic          mem_req,
  input logic [W-1:0]  mem_addr,
  input logic          busy
);
  AST_NO_DUAL_LOAD: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && pc_load)); // R10

  AST_MEM_REQUEST: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !busy && cmd == 3'd1) |-> (mem_req && !pc_load && !link_we)); // R4

  AST_CALL_LINK: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !busy && cmd == 3'd3) |->
      (link_we && pc_load && link_dst == RW'(7) && link_data == $past(pc_inc))); // R6

  AST_TRAP_ISSUE: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !busy && cmd == 3'd4) |->
      (mem_req && busy && !pc_load && mem_addr == {{(W-8){1'b0}}, $past(instr[7:0])})); // R7

  AST_TRAP_FINISH: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && busy) |-> (pc_load && !busy && pc_next == $past(tbl_data))); // R8

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && busy) |-> (!mem_req && !link_we && $stable(sum_q))); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !busy && (cmd == 3'd0 || cmd > 3'd4)) |-> (!mem_req && !pc_load && !link_we)); // R12
endmodule

bind cf_addr_unit cfa_checker #(.W(W), .RW(RW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd       (cmd),
  .instr     (instr),
  .pc_inc    (pc_inc),
  .tbl_data  (tbl_data),
  .sum_q     (sum_q),
  .pc_next   (pc_next),
  .pc_load   (pc_load),
  .link_we   (link_we),
  .link_dst  (link_dst),
  .link_data (link_data),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .busy      (busy)
);

// File: tb/cf_addr_unit_test.sv
module cf_addr_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd = '0;
  logic        base_sel = 1'b0;
  logic [1:0]  off_sel = '0;
  logic        br_take = 1'b0;
  logic [15:0] instr = '0, pc_inc = '0, base_val = '0, tbl_data = '0;
  logic [15:0] sum_q, pc_next, link_data, mem_addr;
  logic        pc_load, link_we, mem_req, busy;
  logic [2:0]  link_dst;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cf_addr_unit uut (
    .clk(clk), .rst(rst), .cmd(cmd), .base_sel(base_sel), .off_sel(off_sel),
    .br_take(br_take), .instr(instr), .pc_inc(pc_inc), .base_val(base_val),
    .tbl_data(tbl_data), .sum_q(sum_q), .pc_next(pc_next), .pc_load(pc_load),
    .link_we(link_we), .link_dst(link_dst), .link_data(link_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .busy(busy)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at the falling edge, sample just after the next rising edge
  task automatic step(input logic [2:0] c, input logic bs, input logic [1:0] os, input logic tk,
                      input logic [15:0] ir, input logic [15:0] pc, input logic [15:0] bv,
                      input logic [15:0] td);
    @(negedge clk);
    cmd = c; base_sel = bs; off_sel = os; br_take = tk;
    instr = ir; pc_inc = pc; base_val = bv; tbl_data = td;
    @(posedge clk);
    #1;
  endtask

  task automatic test_reset();
    chk("R1", "pc_load", {15'b0, pc_load}, 16'd0);
    chk("R1", "link_we", {15'b0, link_we}, 16'd0);
    chk("R1", "mem_req", {15'b0, mem_req}, 16'd0);
    chk("R1", "busy", {15'b0, busy}, 16'd0);
    chk("R1", "sum_q", sum_q, 16'd0);
    chk("R1", "pc_next", pc_next, 16'd0);
    chk("R1", "mem_addr", mem_addr, 16'd0);
  endtask

  task automatic test_mem_reg_off6();
    // base register 0x1000 + sext(6'h3F = -1); dst field instr[11:9]=5
    step(3'd1, 1'b1, 2'd0, 1'b0, 16'h0A3F, 16'h3001, 16'h1000, 16'h0);
    chk("R4", "mem_req", {15'b0, mem_req}, 16'd1);
    chk("R4", "mem_addr", mem_addr, 16'h0FFF);
    chk("R4", "pc_load", {15'b0, pc_load}, 16'd0);
    chk("R3", "sum_q off6", sum_q, 16'h0FFF);
    chk("R11", "link_dst", {13'b0, link_dst}, 16'd5);
    chk("R11", "link_we", {15'b0, link_we}, 16'd0);
  endtask

  task automatic test_mem_pc_off9();
    // PC 0x3001 + sext(9'h100 = -256)
    step(3'd1, 1'b0, 2'd1, 1'b0, 16'h0100, 16'h3001, 16'h1234, 16'h0);
    chk("R2", "pc base mem_addr", mem_addr, 16'h2F01);
  endtask

  task automatic test_branch();
    step(3'd2, 1'b0, 2'd1, 1'b1, 16'h00FF, 16'h4000, 16'h0, 16'h0);
    chk("R5", "taken pc_load", {15'b0, pc_load}, 16'd1);
    chk("R5", "taken pc_next", pc_next, 16'h40FF);
    chk("R5", "mem_req", {15'b0, mem_req}, 16'd0);
    step(3'd2, 1'b0, 2'd1, 1'b0, 16'h00FF, 16'h4000, 16'h0, 16'h0);
    chk("R5", "not taken pc_load", {15'b0, pc_load}, 16'd0);
  endtask

  task automatic test_wrap_zero();
    // 0xFFFF + sext(6'h01) wraps to 0
    step(3'd0, 1'b0, 2'd0, 1'b0, 16'h0001, 16'hFFFF, 16'h0, 16'h0);
    chk("R2", "wrap sum_q", sum_q, 16'h0000);
    chk("R12", "idle pc_load", {15'b0, pc_load}, 16'd0);
    // zero offset: the sum is the base itself
    step(3'd0, 1'b1, 2'd3, 1'b0, 16'hFFFF, 16'h1111, 16'h5A5A, 16'h0);
    chk("R3", "zero offset sum_q", sum_q, 16'h5A5A);
  endtask

  task automatic test_calls();
    // PC-relative call: 0x3000 + sext(11'h400 = -1024)
    step(3'd3, 1'b0, 2'd2, 1'b0, 16'h0C00, 16'h3000, 16'h0, 16'h0);
    chk("R6", "rel pc_next", pc_next, 16'h2C00);
    chk("R6", "rel pc_load", {15'b0, pc_load}, 16'd1);
    chk("R6", "rel link_we", {15'b0, link_we}, 16'd1);
    chk("R6", "rel link_dst", {13'b0, link_dst}, 16'd7);
    chk("R6", "rel link_data", link_data, 16'h3000);
    // register call: base register plus zero offset
    step(3'd3, 1'b1, 2'd3, 1'b0, 16'h0000, 16'h3100, 16'hABCD, 16'h0);
    chk("R6", "reg pc_next", pc_next, 16'hABCD);
    chk("R6", "reg link_data", link_data, 16'h3100);
  endtask

  task automatic test_trap();
    step(3'd4, 1'b0, 2'd0, 1'b0, 16'hF2FF, 16'h3050, 16'h0, 16'h0);
    chk("R7", "mem_req", {15'b0, mem_req}, 16'd1);
    chk("R7", "mem_addr", mem_addr, 16'h00FF);
    chk("R7", "busy", {15'b0, busy}, 16'd1);
    chk("R7", "pc_load", {15'b0, pc_load}, 16'd0);
    chk("R7", "link_dst", {13'b0, link_dst}, 16'd7);
    chk("R7", "link_data", link_data, 16'h3050);
    begin
      logic [15:0] held;
      held = sum_q;
      // collision: memory command offered while the trap completes
      step(3'd1, 1'b1, 2'd0, 1'b0, 16'h0001, 16'h0, 16'h2000, 16'h0400);
      chk("R8", "pc_load", {15'b0, pc_load}, 16'd1);
      chk("R8", "pc_next", pc_next, 16'h0400);
      chk("R8", "busy", {15'b0, busy}, 16'd0);
      chk("R9", "mem_req", {15'b0, mem_req}, 16'd0);
      chk("R9", "link_we", {15'b0, link_we}, 16'd0);
      chk("R9", "sum_q held", sum_q, held);
    end
    step(3'd0, 1'b0, 2'd0, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0);
    chk("R12", "after trap pc_load", {15'b0, pc_load}, 16'd0);
  endtask

  task automatic test_undefined();
    for (int k = 5; k < 8; k++) begin
      step(3'(k), 1'b0, 2'd0, 1'b1, 16'h0E05, 16'h2222, 16'h0, 16'h0);
      chk("R12", "undef mem_req", {15'b0, mem_req}, 16'd0);
      chk("R12", "undef pc_load", {15'b0, pc_load}, 16'd0);
      chk("R12", "undef link_we", {15'b0, link_we}, 16'd0);
      chk("R10", "no dual load", {15'b0, mem_req & pc_load}, 16'd0);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    test_reset();
    @(negedge clk);
    rst = 1'b0;
    test_mem_reg_off6();
    test_mem_pc_off9();
    test_branch();
    test_wrap_zero();
    test_calls();
    test_trap();
    test_undefined();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule